// File: doc/BRIEF.md
# Credit-Gated Packet Transmit Permission

This block sits on the sending side of a point-to-point link. It decides, cycle by cycle, whether the packet at the head of the transmit queue may leave, based on buffer credit that the far-end receiver has advertised. Two free-running modular counters hold the state: a credit limit and a consumed-credit total. The limit is loaded once from the receiver's initial advertisement and is then raised by each credit-return update. The consumed total grows by the cost of every packet sent.

Permission is never computed from an up/down occupancy count. The gate subtracts the consumed total and the candidate cost from the limit modulo 2^N and compares the result against half the counter range. Both counters can therefore wrap freely. An initial advertisement of zero switches the gate into unlimited mode, and in that mode every request is granted.

The packet request is a valid/ready stream. The sender raises `req_valid` with `req_cost` and holds both steady until it sees `req_ready` high at a rising clock edge. That cycle is the grant. `req_ready` depends on the presented cost and the counters, never on `req_valid`. A request that does not fit just waits, and it is judged again on every cycle. The initial-credit load and the credit-return inputs are plain single-cycle strobes with no back-pressure.

Top module: `fc_credit_gate`

## Requirements
- R1: After reset the limit and consumed counters are both 0 and the gate is in metered mode. `avail_credit` reads 0 and any request of nonzero cost is refused.
- R2: An `init_valid` cycle loads the limit with `init_limit` and clears the consumed counter. In that cycle `req_ready` is 0 and any credit return is ignored.
- R3: In metered mode, and outside an init cycle, `req_ready` is 1 exactly when (limit − consumed − cost) mod 2^N ≤ 2^(N−1). An exact fit is allowed, and an advertisement above 2^(N−1) refuses small costs.
- R4: A grant (`req_valid` and `req_ready` at a rising edge) in metered mode adds `req_cost` to the consumed counter mod 2^N.
- R5: A `ret_valid` cycle in metered mode, outside an init cycle, adds `ret_amount` to the limit mod 2^N.
- R6: A grant and a credit return in the same cycle are both applied.
- R7: A refused request leaves the consumed counter unchanged. It is granted in the first cycle in which credit returns make it fit, with no need to drop `req_valid`.
- R8: An `init_limit` of 0 selects unlimited mode. In that mode `req_ready` is 1 outside init cycles, both counters hold, credit returns are ignored and `avail_credit` stays 0, until a later init with a nonzero value restores metered mode.
- R9: `avail_credit` always equals (limit − consumed) mod 2^N of the registered counters.
- R10: Grants and returns remain correct when either counter wraps past 2^N − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet waiting to be sent |
| req_cost | input | COST_W | Credit cost of the waiting packet |
| req_ready | output | 1 | Packet may be sent this cycle |
| init_valid | input | 1 | Load the initial credit advertisement |
| init_limit | input | CNT_W | Advertised initial limit (0 = unlimited) |
| ret_valid | input | 1 | Credit-return update present |
| ret_amount | input | CNT_W | Credit returned by the receiver |
| avail_credit | output | CNT_W | (limit − consumed) mod 2^CNT_W |

## Verification
The bench builds the gate with CNT_W = 8 and COST_W = 6. The half-range threshold then falls at 128, so both counters wrap after a few dozen grants and returns, and R10 can be exercised in a short run. The small width also puts the threshold edge within reach: an advertisement of 130 lets a cost of 2 through and refuses a cost of 1. That shows the modular window refusing an advertisement that is larger than the window.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    FC_METERED   = 1'b0,
    FC_UNLIMITED = 1'b1
  } fc_mode_e;
endpackage

// File: rtl/fc_limit_reg.sv
module fc_limit_reg
  import fc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_valid,
  input  logic [CNT_W-1:0] init_limit,
  input  logic             ret_valid,
  input  logic [CNT_W-1:0] ret_amount,
  output logic [CNT_W-1:0] limit_q,
  output fc_mode_e         mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
      mode_q  <= FC_METERED;
    end else if (init_valid) begin
      limit_q <= init_limit;
      mode_q  <= (init_limit == '0) ? FC_UNLIMITED : FC_METERED;
    end else if (ret_valid && mode_q == FC_METERED) begin
      limit_q <= limit_q + ret_amount;
    end
  end

  // R2: an init strobe loads the advertised limit
  assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> limit_q == $past(init_limit));

  // R5: a metered return raises the limit by the returned amount
  assert_return_adds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !init_valid && mode_q == FC_METERED)
      |=> limit_q == $past(limit_q + ret_amount));
endmodule

// File: rtl/fc_consumed_ctr.sv
module fc_consumed_ctr #(
  parameter int CNT_W  = 12,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [COST_W-1:0] add_cost,
  output logic [CNT_W-1:0]  consumed_q
);
  localparam int PAD_W = CNT_W - COST_W;
  logic [CNT_W-1:0] cost_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cost_ext = {{PAD_W{1'b0}}, add_cost};
    end else begin : g_nopad
      assign cost_ext = add_cost[CNT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      consumed_q <= '0;
    else if (clear)  consumed_q <= '0;
    else if (add_en) consumed_q <= consumed_q + cost_ext;
  end

  // R4: each accepted packet adds its cost
  assert_grant_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clear) |=> consumed_q == $past(consumed_q + cost_ext));

  // R2: init clears the consumed total
  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> consumed_q == '0);
endmodule

// File: rtl/fc_permit_check.sv
module fc_permit_check
  import fc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int COST_W = 8
) (
  input  logic [CNT_W-1:0]  limit_q,
  input  logic [CNT_W-1:0]  consumed_q,
  input  logic [COST_W-1:0] cost,
  input  fc_mode_e          mode_q,
  input  logic              init_busy,
  output logic              permit,
  output logic [CNT_W-1:0]  avail
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};
  localparam int PAD_W = CNT_W - COST_W;

  logic [CNT_W-1:0] cost_ext;
  logic [CNT_W-1:0] remaining;
  logic             fits;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cost_ext = {{PAD_W{1'b0}}, cost};
    end else begin : g_nopad
      assign cost_ext = cost[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    avail     = limit_q - consumed_q;
    remaining = avail - cost_ext;
    fits      = (remaining <= HALF);
    permit    = !init_busy && ((mode_q == FC_UNLIMITED) || fits);
  end
endmodule

// File: rtl/fc_credit_gate.sv
module fc_credit_gate
  import fc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [COST_W-1:0] req_cost,
  output logic              req_ready,
  input  logic              init_valid,
  input  logic [CNT_W-1:0]  init_limit,
  input  logic              ret_valid,
  input  logic [CNT_W-1:0]  ret_amount,
  output logic [CNT_W-1:0]  avail_credit
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] consumed_q;
  fc_mode_e         mode_q;
  logic             grant;

  assign grant = req_valid && req_ready && (mode_q == FC_METERED);

  fc_limit_reg #(.CNT_W(CNT_W)) u_limit (
    .clk(clk), .rst_n(rst_n),
    .init_valid(init_valid), .init_limit(init_limit),
    .ret_valid(ret_valid), .ret_amount(ret_amount),
    .limit_q(limit_q), .mode_q(mode_q)
  );

  fc_consumed_ctr #(.CNT_W(CNT_W), .COST_W(COST_W)) u_consumed (
    .clk(clk), .rst_n(rst_n),
    .clear(init_valid), .add_en(grant), .add_cost(req_cost),
    .consumed_q(consumed_q)
  );

  fc_permit_check #(.CNT_W(CNT_W), .COST_W(COST_W)) u_check (
    .limit_q(limit_q), .consumed_q(consumed_q), .cost(req_cost),
    .mode_q(mode_q), .init_busy(init_valid),
    .permit(req_ready), .avail(avail_credit)
  );

  // R3: a metered grant never leaves more than half the range outstanding
  assert_window_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !ret_valid && !init_valid) |=> avail_credit <= HALF);

  // R7: a refused request consumes nothing
  assert_stall_no_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !init_valid) |=> $stable(consumed_q));

  // R8: unlimited mode accepts everything and freezes both counters
  assert_unlimited_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FC_UNLIMITED && !init_valid) |-> req_ready);
  assert_unlimited_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FC_UNLIMITED && !init_valid) |=> ($stable(consumed_q) && $stable(limit_q)));

  // R2: no packet accepted in an init cycle
  assert_init_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |-> !req_ready);
endmodule

// File: tb/fc_credit_gate_bench.sv
module fc_credit_gate_bench;
  localparam int CW = 8;
  localparam int KW = 6;
  localparam int MASK = (1 << CW) - 1;
  localparam int HALF = 1 << (CW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [KW-1:0] req_cost = '0;
  logic          req_ready;
  logic          init_valid = 1'b0;
  logic [CW-1:0] init_limit = '0;
  logic          ret_valid = 1'b0;
  logic [CW-1:0] ret_amount = '0;
  logic [CW-1:0] avail_credit;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_limit = 0;
  int m_cons = 0;
  bit m_unl = 1'b0;

  always #4 clk = ~clk;

  fc_credit_gate #(.CNT_W(CW), .COST_W(KW)) u_fc_credit_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cost(req_cost), .req_ready(req_ready),
    .init_valid(init_valid), .init_limit(init_limit),
    .ret_valid(ret_valid), .ret_amount(ret_amount),
    .avail_credit(avail_credit)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, check ready, clock, check avail.
  task automatic cycle(string req, bit rv, int cost, bit iv, int il, bit tv, int ta);
    bit exp_rdy;
    req_valid = rv; req_cost = cost[KW-1:0];
    init_valid = iv; init_limit = il[CW-1:0];
    ret_valid = tv; ret_amount = ta[CW-1:0];
    #1;
    exp_rdy = !iv && (m_unl || (((m_limit - m_cons - cost) & MASK) <= HALF));
    if (rv) check({req, " ready"}, int'(req_ready), int'(exp_rdy));
    @(posedge clk);
    if (iv) begin
      m_limit = il & MASK; m_cons = 0; m_unl = (il == 0);
    end else if (!m_unl) begin
      if (rv && exp_rdy) m_cons = (m_cons + cost) & MASK;
      if (tv) m_limit = (m_limit + ta) & MASK;
    end
    @(negedge clk);
    #1;
    check({req, " avail"}, int'(avail_credit), (m_limit - m_cons) & MASK);
    req_valid = 0; init_valid = 0; ret_valid = 0;
  endtask

  task automatic test_reset_R1();
    check("R1 avail after reset", int'(avail_credit), 0);
    cycle("R1 cost1 refused", 1, 1, 0, 0, 0, 0);
    check("R1 refused explicitly", int'(req_ready), 0);
  endtask

  task automatic test_init_R2();
    cycle("R2 init with request and return", 1, 1, 1, 40, 1, 5);
    check("R2 limit loaded", int'(avail_credit), 40);
  endtask

  task automatic test_fit_R3_R4_R5();
    cycle("R3 cost41 over", 1, 41, 0, 0, 0, 0);
    cycle("R3 exact fit 40", 1, 40, 0, 0, 0, 0);
    check("R4 consumed all", int'(avail_credit), 0);
    cycle("R5 return 10", 0, 0, 0, 0, 1, 10);
    check("R5 avail raised", int'(avail_credit), 10);
  endtask

  task automatic test_same_cycle_R6();
    cycle("R6 grant4 plus return7", 1, 4, 0, 0, 1, 7);
    check("R6 both applied", int'(avail_credit), 13);
  endtask

  task automatic test_stall_R7();
    cycle("R7 cost20 waits", 1, 20, 0, 0, 0, 0);
    cycle("R7 cost20 waits again", 1, 20, 0, 0, 0, 0);
    check("R7 nothing consumed", int'(avail_credit), 13);
    cycle("R7 return while waiting", 1, 20, 0, 0, 1, 7);
    cycle("R7 now granted", 1, 20, 0, 0, 0, 0);
    check("R7 consumed after fit", int'(avail_credit), 0);
  endtask

  task automatic test_half_R3();
    cycle("R3 init 130", 0, 0, 1, 130, 0, 0);
    cycle("R3 cost1 above window", 1, 1, 0, 0, 0, 0);
    cycle("R3 cost2 on window edge", 1, 2, 0, 0, 0, 0);
    check("R3 edge avail", int'(avail_credit), 128);
    cycle("R3 init 200", 0, 0, 1, 200, 0, 0);
    cycle("R3 big advert refuses", 1, 63, 0, 0, 0, 0);
  endtask

  task automatic test_unlimited_R8();
    cycle("R8 init zero", 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cycle("R8 always granted", 1, 63, 0, 0, 0, 0);
    cycle("R8 return ignored", 1, 17, 0, 0, 1, 50);
    check("R8 avail zero", int'(avail_credit), 0);
    cycle("R8 back to metered", 0, 0, 1, 10, 0, 0);
    cycle("R8 metered refuses 11", 1, 11, 0, 0, 0, 0);
  endtask

  task automatic test_wrap_R10();
    cycle("R10 init 100", 0, 0, 1, 100, 0, 0);
    for (int i = 0; i < 24; i++) begin
      cycle("R10 grant50", 1, 50, 0, 0, 0, 0);
      cycle("R10 return50", 0, 0, 0, 0, 1, 50);
    end
    for (int i = 0; i < 12; i++) cycle("R10 grant+return", 1, 37, 0, 0, 1, 37);
    cycle("R10 drain 63", 1, 63, 0, 0, 0, 0);
    cycle("R10 drain 37", 1, 37, 0, 0, 0, 0);
    cycle("R10 one over", 1, 1, 0, 0, 0, 0);
    check("R10 R9 empty after wrap", int'(avail_credit), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    test_reset_R1();
    test_init_R2();
    test_fit_R3_R4_R5();
    test_same_cycle_R6();
    test_stall_R7();
    test_half_R3();
    test_unlimited_R8();
    test_wrap_R10();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule